// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two K-bit two's-complement numbers over several clock cycles using one K+1-bit adder/subtractor. When started, it captures the multiplicand and places the multiplier in the low half of a 2K-bit partial-product register whose upper half is cleared. On every step it looks at the register's least significant bit, which is the next unused multiplier bit. It adds either the multiplicand or zero to the upper half, then shifts the whole register right by one place. The sign of the sum fills the vacated top bit. As the register shifts, the spent multiplier bits drop out of the low end. On the step that handles the multiplier's sign bit, the block subtracts the multiplicand instead of adding it, so a negative multiplier gives the correct result with no pre- or post-correction.

The controller is a three-state machine. ST_IDLE waits for a start pulse; the transition on start loads the operands and is named LOAD. ST_RUN performs one step per cycle. It stays in ST_RUN (transition STEP) until the K-th step, then leaves it (transition LAST). ST_FINISH lasts one cycle and raises the done pulse. It then returns unconditionally to ST_IDLE (transition RETIRE). The product output is the partial-product register itself. After done it holds the finished result until the next accepted start.

Top module: `seqmul_top`

## Requirements
- R1: After reset, busy is 0, done is 0 and product is all zeros.
- R2: A start sampled high while the block is idle sets busy high from the next cycle. Busy then stays high for exactly K+1 cycles: K step cycles and one finish cycle.
- R3: The done pulse is high for exactly one cycle, the (K+1)-th cycle after the accepted start edge, which is the last cycle with busy high.
- R4: While done is high, product equals the signed product of the multiplicand and multiplier as a 2K-bit two's-complement value, for every combination of operand signs.
- R5: A zero operand gives an all-zero product, in either operand position. The most negative value −2^(K−1) in either operand gives the correct signed product.
- R6: Once done has fallen, product keeps its value while the block is idle, whatever the operand inputs do, until the next accepted start.
- R7: A start that arrives while busy is high has no effect: the running operation keeps its timing and its result.
- R8: With a negative multiplier, the step for the multiplier's sign bit subtracts the multiplicand. For K = 5, −10 × −11 gives 110 and −10 × 11 gives −110.
- R9: The intermediate sum is formed with K+1 bits, so a high-half overflow does not corrupt the sign extension. For K = 5, −16 × −16 gives 256 and −16 × −1 gives 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | K | Multiplicand, two's complement |
| mplier | input | K | Multiplier, two's complement |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2K | Partial-product register; the signed product when done |

## Verification
Assertions check the following on every cycle:
- done never lasts longer than one cycle;
- done always follows the last step;
- the step counter advances by one in every step cycle;
- no load can happen while busy;
- an accepted start places the multiplier, unaltered, in the low half with the high half cleared;
- the register does not change in cycles with neither a load nor a step.

Only the bench scenarios can show that the final value is numerically correct. These include all sign combinations, zero and most-negative operands, the subtracting sign-bit step and high-half overflow. The scenarios also show that the product holds while the inputs change, and that a start arriving mid-operation leaves result and timing untouched.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int K = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load_en,
    output logic step_en,
    output logic last_step,
    output logic busy,
    output logic done
);

    localparam int CW = (K > 2) ? $clog2(K) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(K - 1);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [CW-1:0]    cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RUN;
            ST_RUN:    if (cnt_q == LAST_IDX) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cnt_q <= '0;
        end else if (state_q == ST_RUN && cnt_q != LAST_IDX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // outputs
    always_comb begin
        load_en   = 1'b0;
        step_en   = 1'b0;
        last_step = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en = start;
            end
            ST_RUN: begin
                busy      = 1'b1;
                step_en   = 1'b1;
                last_step = (cnt_q == LAST_IDX);
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_step |=> done);

    // R2
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !last_step) |=> (step_en && cnt_q == $past(cnt_q) + CW'(1)));

    // R7
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load_en);

endmodule

// File: rtl/seqmul_addsub.sv
module seqmul_addsub #(
    parameter int K = 8
) (
    input  logic [K-1:0] upper,
    input  logic [K-1:0] opnd,
    input  logic         sub,
    output logic [K:0]   sum
);

    logic [K:0] upper_x;
    logic [K:0] opnd_x;
    logic [K:0] opnd_inv;

    always_comb begin
        upper_x  = {upper[K-1], upper};
        opnd_x   = {opnd[K-1], opnd};
        opnd_inv = opnd_x ^ {(K+1){sub}};
        sum      = upper_x + opnd_inv + {{K{1'b0}}, sub};
    end

endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath #(
    parameter int K = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic           step_en,
    input  logic           last_step,
    input  logic [K-1:0]   mcand,
    input  logic [K-1:0]   mplier,
    output logic [2*K-1:0] product
);

    localparam int PW = 2 * K;

    logic [K-1:0]  mcand_q;
    logic [PW-1:0] pp_q;
    logic [K-1:0]  addend;
    logic [K:0]    sum;
    logic          cur_bit;

    assign cur_bit = pp_q[0];

    // operand select: multiplicand gated by the current multiplier bit
    for (genvar i = 0; i < K; i++) begin : g_gate
        assign addend[i] = mcand_q[i] & cur_bit;
    end

    seqmul_addsub #(.K(K)) u_addsub (
        .upper (pp_q[PW-1:K]),
        .opnd  (addend),
        .sub   (last_step),
        .sum   (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            pp_q    <= '0;
        end else if (load_en) begin
            mcand_q <= mcand;
            pp_q    <= {{K{1'b0}}, mplier};
        end else if (step_en) begin
            pp_q    <= {sum, pp_q[K-1:1]};
        end
    end

    assign product = pp_q;

    // R2
    load_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (pp_q == {{K{1'b0}}, $past(mplier)}));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(pp_q));

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top #(
    parameter int K = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [K-1:0]   mcand,
    input  logic [K-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*K-1:0] product
);

    logic load_en;
    logic step_en;
    logic last_step;

    seqmul_ctrl #(.K(K)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_en   (load_en),
        .step_en   (step_en),
        .last_step (last_step),
        .busy      (busy),
        .done      (done)
    );

    seqmul_datapath #(.K(K)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .step_en   (step_en),
        .last_step (last_step),
        .mcand     (mcand),
        .mplier    (mplier),
        .product   (product)
    );

    // R2
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> busy);

endmodule

// File: tb/seqmul_top_test.sv
`timescale 1ns/1ps
module seqmul_top_test;

    localparam int W  = 5;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int     checks = 0;
    int     errors = 0;
    int     cycles = 0;
    string  tag = "R1";

    // behavioural reference model
    int            m_phase = 0;
    int            m_left = 0;
    logic [PW-1:0] m_exp = '0;
    bit            m_have = 0;

    always #4 clk = ~clk;

    seqmul_top #(.K(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    function automatic logic [PW-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] x);
        longint pa;
        longint px;
        longint r;
        pa = longint'($signed(a));
        px = longint'($signed(x));
        r  = pa * px;
        return r[PW-1:0];
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_phase <= 0;
            m_left  <= 0;
            m_have  <= 0;
            m_exp   <= '0;
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_phase <= 1;
                    m_left  <= W;
                    m_exp   <= ref_mul(mcand, mplier);
                end
                1: if (m_left == 1) m_phase <= 2;
                   else m_left <= m_left - 1;
                default: begin
                    m_phase <= 0;
                    m_have  <= 1;
                end
            endcase
        end
    end

    task automatic check(bit ok, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (m_phase != 0), "busy", PW'(busy), PW'(m_phase != 0));
            check(done == (m_phase == 2), "done", PW'(done), PW'(m_phase == 2));
            if (m_phase == 2)
                check(product == m_exp, "product at done", product, m_exp);
            else if (m_phase == 0 && m_have)
                check(product == m_exp, "held product", product, m_exp);
        end
    end

    task automatic run_op(logic [W-1:0] a, logic [W-1:0] x);
        @(negedge clk);
        while (busy) @(negedge clk);
        start  = 1'b1;
        mcand  = a;
        mplier = x;
        @(negedge clk);
        start  = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check(busy == 1'b0, "reset busy", PW'(busy), '0);
        check(done == 1'b0, "reset done", PW'(done), '0);
        check(product == '0, "reset product", product, '0);
        rst_n = 1'b1;
        @(negedge clk);

        tag = "R8";
        run_op(5'b10110, 5'b10101);   // -10 * -11 = 110
        check(product == PW'(110), "neg*neg", product, PW'(110));
        run_op(5'b10110, 5'b01011);   // -10 * 11 = -110
        check(product == ref_mul(5'b10110, 5'b01011), "neg*pos", product,
              ref_mul(5'b10110, 5'b01011));

        tag = "R9";
        run_op(5'b10000, 5'b10000);   // -16 * -16 = 256
        check(product == PW'(256), "minneg squared", product, PW'(256));
        run_op(5'b10000, 5'b11111);   // -16 * -1 = 16
        check(product == PW'(16), "minneg*-1", product, PW'(16));

        tag = "R5";
        run_op(5'd0, 5'b10000);
        run_op(5'b10000, 5'd0);
        run_op(5'd7, 5'b10000);
        run_op(5'b10000, 5'd9);
        run_op(5'd0, 5'd0);

        tag = "R6";
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            mcand  = W'(i * 7 + 3);
            mplier = W'(i * 5 + 1);
        end

        tag = "R7";
        @(negedge clk);
        start = 1'b1; mcand = 5'd13; mplier = 5'b11101;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1; mcand = 5'd1; mplier = 5'd1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check(product == ref_mul(5'd13, 5'b11101), "busy start ignored", product,
              ref_mul(5'd13, 5'b11101));

        tag = "R2";
        run_op(5'd3, 5'd4);
        tag = "R3";
        run_op(5'b11001, 5'd6);

        tag = "R4";
        for (int a = 0; a < (1 << W); a++) begin
            for (int x = 0; x < (1 << W); x++) begin
                run_op(W'(a), W'(x));
            end
        end

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule